// File: doc/BRIEF.md
# Programmable Dotclock Panel Timing Generator

This block produces the line sync, frame sync, data-enable and pixel-request strobes that a parallel RGB panel needs. Each strobe is derived from a horizontal position counter and a vertical position counter. The horizontal counter advances once per pixel-clock enable. The vertical counter advances once per completed line. All geometry comes from configuration inputs: total line length, sync pulse widths, cumulative wait counts and active extents. Every wait count is measured from the leading edge of the sync pulse, so the wait already includes the sync width and the back porch.

Software programs the geometry while the sync outputs are switched off. It then turns the sync outputs on, and only afterwards enables pixel fetching with the run input. The configuration is captured in shadow registers. These registers load continuously while sync is off, and after that only at the step where the frame wraps to its first pixel. A frame that is already on the panel is therefore never disturbed by a change. Each sync strobe and the data enable has its own polarity select. A one-clock frame-start pulse marks the first pixel step of every frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: With the shadowed line length set to P, the horizontal position runs from 0 to P-1, advancing one step per cycle with `pix_en_i` high, and then returns to 0. One line is therefore P pixel steps.
- R2: The line sync is active for positions below the shadowed hsync width.
- R3: A frame is the shadowed frame length in lines. The vertical position advances once per completed line. The frame sync is active for lines below the shadowed vsync width.
- R4: Data enable is active only when both of these hold: the horizontal position is at or above the horizontal wait and below the wait plus the active width, and the vertical position is at or above the vertical wait and below the wait plus the active height.
- R5: The polarity inputs `hsync_pol_i`, `vsync_pol_i` and `de_pol_i` act immediately and are not shadowed. A value of 1 makes the matching output high when active. A value of 0 makes it low when active. The inactive level is always the inverse.
- R6: `pix_req_o` is high exactly when data enable is active and `run_i` is high. It is always active-high.
- R7: `frame_start_o` is high for one clock for each pixel step taken at position (0,0).
- R8: While `pix_en_i` is low the position holds, so every output repeats its previous value.
- R9: While `sync_on_i` is low, both positions are cleared and the outputs sit at their inactive levels. `pix_req_o` and `frame_start_o` stay low. The first step after `sync_on_i` rises is position (0,0).
- R10: The geometry inputs are captured while `sync_on_i` is low, and otherwise only at the step where the frame wraps. A change made mid-frame takes effect from the next frame.
- R11: While `rst_ni` is low, all five outputs are 0.
- R12: The outputs are registered. The values sampled after a clock edge describe the position the counters held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; one pixel step per high cycle |
| sync_on_i | input | 1 | Sync outputs enabled; low clears the position counters |
| run_i | input | 1 | Pixel fetch enable, gates `pix_req_o` |
| h_period_i | input | 18 | Total line length in pixel steps |
| h_pulse_i | input | 14 | Line sync width in pixel steps |
| h_wait_i | input | 12 | Pixel steps from line start to first active pixel |
| h_active_i | input | 18 | Active pixels per line |
| v_period_i | input | 16 | Total frame length in lines |
| v_pulse_i | input | 18 | Frame sync width in lines |
| v_wait_i | input | 16 | Lines from frame start to first active line |
| v_active_i | input | 16 | Active lines per frame |
| hsync_pol_i | input | 1 | 1 = line sync active high |
| vsync_pol_i | input | 1 | 1 = frame sync active high |
| de_pol_i | input | 1 | 1 = data enable active high |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Pixel request to the fetch engine |
| frame_start_o | output | 1 | One-clock pulse at the first pixel step of a frame |

## Verification
The assertions check the following on every cycle:
- Neither counter ever reaches its shadowed limit.
- A held pixel enable freezes the position.
- The shadow copy changes only on a load.
- The frame-start pulse never lasts two clocks.
- A switched-off generator raises neither the request nor the frame-start pulse.
- A pixel request always comes with data enable at its active level.

Only the directed scenarios can show the geometry itself: the exact sync widths, the window edges, the frame and line lengths with and without enable gaps, the deferral of a mid-frame change to the next frame, and the restart at (0,0) after sync is switched back on. The bench compares these against its own position model, cycle by cycle.

// File: rtl/lcd_timing_pkg.sv
`timescale 1ns/1ps
package lcd_timing_pkg;
  localparam int HPER_W  = 18;
  localparam int HPW_W   = 14;
  localparam int HWAIT_W = 12;
  localparam int HACT_W  = 18;
  localparam int VPER_W  = 16;
  localparam int VPW_W   = 18;
  localparam int VWAIT_W = 16;
  localparam int VACT_W  = 16;
  localparam int CFG_W   = HPER_W + HPW_W + HWAIT_W + HACT_W +
                           VPER_W + VPW_W + VWAIT_W + VACT_W;

  typedef struct packed {
    logic [HPER_W-1:0]  h_per;
    logic [HPW_W-1:0]   h_pw;
    logic [HWAIT_W-1:0] h_wait;
    logic [HACT_W-1:0]  h_act;
    logic [VPER_W-1:0]  v_per;
    logic [VPW_W-1:0]   v_pw;
    logic [VWAIT_W-1:0] v_wait;
    logic [VACT_W-1:0]  v_act;
  } timing_cfg_t;
endpackage

// File: rtl/lcd_cfg_shadow.sv
`timescale 1ns/1ps
module lcd_cfg_shadow
  import lcd_timing_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  timing_cfg_t cfg_i,
  output timing_cfg_t cfg_o
);
  timing_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  // R10: shadow only moves on a load
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/lcd_axis_counter.sv
`timescale 1ns/1ps
module lcd_axis_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == limit_i - ONE);
  assign wrap_o = step_i && last;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + ONE;
  end

  // R1/R3: position never reaches the programmed period
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i != '0) |-> (cnt_q < limit_i));

  // R8: no step, no movement
  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lcd_axis_window.sv
`timescale 1ns/1ps
module lcd_axis_window #(
  parameter int CNT_W  = 16,
  parameter int PW_W   = 16,
  parameter int WAIT_W = 16,
  parameter int ACT_W  = 16
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [ACT_W-1:0]  act_i,
  output logic              sync_o,
  output logic              win_o
);
  localparam int M1    = (CNT_W > PW_W) ? CNT_W : PW_W;
  localparam int M2    = (WAIT_W > ACT_W) ? WAIT_W : ACT_W;
  localparam int EXT_W = ((M1 > M2) ? M1 : M2) + 1;

  logic [EXT_W-1:0] c, pw, wt, ac, wt_end;

  always_comb begin
    c      = EXT_W'(cnt_i);
    pw     = EXT_W'(pw_i);
    wt     = EXT_W'(wait_i);
    ac     = EXT_W'(act_i);
    wt_end = wt + ac;
    sync_o = (c < pw);
    win_o  = (c >= wt) && (c < wt_end);
  end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
  import lcd_timing_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pix_en_i,
  input  logic               sync_on_i,
  input  logic               run_i,
  input  logic [HPER_W-1:0]  h_period_i,
  input  logic [HPW_W-1:0]   h_pulse_i,
  input  logic [HWAIT_W-1:0] h_wait_i,
  input  logic [HACT_W-1:0]  h_active_i,
  input  logic [VPER_W-1:0]  v_period_i,
  input  logic [VPW_W-1:0]   v_pulse_i,
  input  logic [VWAIT_W-1:0] v_wait_i,
  input  logic [VACT_W-1:0]  v_active_i,
  input  logic               hsync_pol_i,
  input  logic               vsync_pol_i,
  input  logic               de_pol_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pix_req_o,
  output logic               frame_start_o
);
  timing_cfg_t       cfg_in, cfg_q;
  logic [HPER_W-1:0] h_cnt;
  logic [VPER_W-1:0] v_cnt;
  logic              h_wrap, v_wrap, cfg_load;
  logic              h_sync, h_win, v_sync, v_win;
  logic              hs_d, vs_d, de_d, req_d, fs_d, in_window;

  assign cfg_in = '{h_per: h_period_i, h_pw: h_pulse_i, h_wait: h_wait_i,
                    h_act: h_active_i, v_per: v_period_i, v_pw: v_pulse_i,
                    v_wait: v_wait_i, v_act: v_active_i};

  // capture while off, or at the step that wraps the frame
  assign cfg_load = !sync_on_i || v_wrap;

  lcd_cfg_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  lcd_axis_counter #(.W(HPER_W)) u_hcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!sync_on_i),
    .step_i  (pix_en_i),
    .limit_i (cfg_q.h_per),
    .cnt_o   (h_cnt),
    .wrap_o  (h_wrap)
  );

  lcd_axis_counter #(.W(VPER_W)) u_vcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!sync_on_i),
    .step_i  (h_wrap),
    .limit_i (cfg_q.v_per),
    .cnt_o   (v_cnt),
    .wrap_o  (v_wrap)
  );

  lcd_axis_window #(.CNT_W(HPER_W), .PW_W(HPW_W), .WAIT_W(HWAIT_W), .ACT_W(HACT_W)) u_hwin (
    .cnt_i  (h_cnt),
    .pw_i   (cfg_q.h_pw),
    .wait_i (cfg_q.h_wait),
    .act_i  (cfg_q.h_act),
    .sync_o (h_sync),
    .win_o  (h_win)
  );

  lcd_axis_window #(.CNT_W(VPER_W), .PW_W(VPW_W), .WAIT_W(VWAIT_W), .ACT_W(VACT_W)) u_vwin (
    .cnt_i  (v_cnt),
    .pw_i   (cfg_q.v_pw),
    .wait_i (cfg_q.v_wait),
    .act_i  (cfg_q.v_act),
    .sync_o (v_sync),
    .win_o  (v_win)
  );

  // active ^ ~pol yields pol when active, ~pol when idle
  always_comb begin
    in_window = sync_on_i && h_win && v_win;
    hs_d  = (sync_on_i && h_sync) ^ ~hsync_pol_i;
    vs_d  = (sync_on_i && v_sync) ^ ~vsync_pol_i;
    de_d  = in_window ^ ~de_pol_i;
    req_d = in_window && run_i;
    fs_d  = sync_on_i && pix_en_i && (h_cnt == '0) && (v_cnt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      pix_req_o     <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= hs_d;
      vsync_o       <= vs_d;
      de_o          <= de_d;
      pix_req_o     <= req_d;
      frame_start_o <= fs_d;
    end
  end

  // R7: frame start lasts one clock
  assert_fs_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && cfg_q.h_per > HPER_W'(1)) |=> !frame_start_o);

  // R9: a switched-off generator neither requests pixels nor starts frames
  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_on_i |=> (!pix_req_o && !frame_start_o));

  // R6: a request only ever comes with data enable at its active level
  assert_req_with_de_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> (de_o == $past(de_pol_i)));
endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_en = 1'b0, sync_on = 1'b0, run = 1'b0;
  logic hpol = 1'b1, vpol = 1'b1, depol = 1'b1;
  int   b_hper = 20, b_hpw = 3, b_hwait = 5, b_hact = 10;
  int   b_vper = 8,  b_vpw = 2, b_vwait = 3, b_vact = 4;
  logic hsync, vsync, de, pix_req, fs;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int mh = 0, mv = 0;
  int s_hper = 0, s_hpw = 0, s_hwait = 0, s_hact = 0;
  int s_vper = 0, s_vpw = 0, s_vwait = 0, s_vact = 0;
  int cyc = 0, last_fs = -1, fs_gap = 0, last_hs = -1, hs_gap = 0;
  logic prev_hs = 1'b0;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en), .sync_on_i(sync_on), .run_i(run),
    .h_period_i(18'(b_hper)), .h_pulse_i(14'(b_hpw)), .h_wait_i(12'(b_hwait)),
    .h_active_i(18'(b_hact)), .v_period_i(16'(b_vper)), .v_pulse_i(18'(b_vpw)),
    .v_wait_i(16'(b_vwait)), .v_active_i(16'(b_vact)),
    .hsync_pol_i(hpol), .vsync_pol_i(vpol), .de_pol_i(depol),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_req_o(pix_req), .frame_start_o(fs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic load_shadow();
    s_hper = b_hper; s_hpw = b_hpw; s_hwait = b_hwait; s_hact = b_hact;
    s_vper = b_vper; s_vpw = b_vpw; s_vwait = b_vwait; s_vact = b_vact;
  endtask

  // One clock. Expected outputs describe the position held before the edge (R12).
  task automatic do_cycle(input bit pe);
    bit ehs, evs, ede, ereq, efs, hw, vw;
    @(negedge clk);
    pix_en = pe;
    hw  = (mh >= s_hwait) && (mh < s_hwait + s_hact);
    vw  = (mv >= s_vwait) && (mv < s_vwait + s_vact);
    ehs = (sync_on && mh < s_hpw) ? hpol : ~hpol;
    evs = (sync_on && mv < s_vpw) ? vpol : ~vpol;
    ede = (sync_on && hw && vw) ? depol : ~depol;
    ereq = sync_on && hw && vw && run;
    efs  = sync_on && pe && mh == 0 && mv == 0;
    if (!sync_on) begin
      mh = 0; mv = 0; load_shadow();
    end else if (pe) begin
      if (mh == s_hper - 1) begin
        mh = 0;
        if (mv == s_vper - 1) begin mv = 0; load_shadow(); end
        else mv++;
      end else mh++;
    end
    @(posedge clk); #1;
    cyc++;
    chk(hsync == ehs,  "R2 hsync", hsync, ehs);
    chk(vsync == evs,  "R3 vsync", vsync, evs);
    chk(de == ede,     "R4 de", de, ede);
    chk(pix_req == ereq, "R6 pix_req", pix_req, ereq);
    chk(fs == efs,     "R7 frame_start", fs, efs);
    if (fs) begin
      if (last_fs >= 0) fs_gap = cyc - last_fs;
      last_fs = cyc;
    end
    if (hsync && !prev_hs) begin
      if (last_hs >= 0) hs_gap = cyc - last_hs;
      last_hs = cyc;
    end
    prev_hs = hsync;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({hsync, vsync, de, pix_req, fs} == 5'b0, "R11 reset outputs",
        {hsync, vsync, de, pix_req, fs}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    load_shadow();
  endtask

  task automatic t_idle_levels();
    hpol = 1; vpol = 1; depol = 1;
    for (int i = 0; i < 4; i++) do_cycle(1);
    chk({hsync, vsync, de} == 3'b000, "R9 idle levels high pol", {hsync, vsync, de}, 0);
    hpol = 0; vpol = 0; depol = 0;
    for (int i = 0; i < 2; i++) do_cycle(1);
    chk({hsync, vsync, de} == 3'b111, "R5 idle levels low pol", {hsync, vsync, de}, 7);
    hpol = 1; vpol = 1; depol = 1;
    do_cycle(1);
  endtask

  task automatic t_basic();
    run = 1; sync_on = 1;
    last_fs = -1; last_hs = -1;
    do_cycle(1);
    chk(fs == 1'b1, "R9 first step at origin", fs, 1);
    for (int i = 0; i < 330; i++) do_cycle(1);
    chk(fs_gap == 160, "R3 frame length", fs_gap, 160);
    chk(hs_gap == 20, "R1 line length", hs_gap, 20);
  endtask

  task automatic t_gaps();
    last_fs = -1; fs_gap = 0;
    for (int i = 0; i < 700; i++) do_cycle(i[0] == 1'b0);
    chk(fs_gap == 320, "R8 frame length with enable gaps", fs_gap, 320);
  endtask

  task automatic t_low_pol_run();
    hpol = 0; vpol = 0; depol = 0;
    for (int i = 0; i < 200; i++) begin
      run = (i < 60 || i > 120);
      do_cycle(1);
    end
    run = 1; hpol = 1; vpol = 1; depol = 1;
    do_cycle(1);
  endtask

  task automatic t_midframe();
    int cnt;
    bit got;
    got = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      do_cycle(1);
      got = fs;
    end
    chk(got, "R7 frame start seen", got, 1);
    b_hpw = 6; b_vact = 2;
    cnt = 0;
    for (int i = 0; i < 159; i++) begin
      do_cycle(1);
      if (hsync) cnt++;
    end
    chk(cnt == 23, "R10 old width kept in current frame", cnt, 23);
    cnt = 0;
    for (int i = 0; i < 160; i++) begin
      do_cycle(1);
      if (hsync) cnt++;
    end
    chk(cnt == 48, "R10 new width in next frame", cnt, 48);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 57; i++) do_cycle(1);
    sync_on = 0;
    for (int i = 0; i < 5; i++) do_cycle(1);
    chk(pix_req == 0 && fs == 0, "R9 off quiet", {pix_req, fs}, 0);
    sync_on = 1;
    do_cycle(1);
    chk(fs == 1'b1, "R9 restart at origin", fs, 1);
    for (int i = 0; i < 40; i++) do_cycle(1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_levels();
    t_basic();
    t_gaps();
    t_low_pol_run();
    t_midframe();
    t_restart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule